// File: doc/BRIEF.md
# Converter Bus Interface and Mode Sequencer

This block is the processor-facing control logic of an 8-bit sampling converter, modelled on a single synchronous clock. It turns active-low chip select, read and write strobes into conversion starts. It holds each result in an output latch and raises an active-low completion interrupt. It drives a data bus with an explicit output enable that stands in for tri-state drivers. Conversion latency is a programmable count of clock cycles. The converted code and an over-range flag are supplied on inputs and captured at the start of each conversion.

Three interface variants share one latch and one interrupt, chosen by `mode_i` and `pipe_i`:
- **Read mode**: a read strobe both starts the conversion and fetches its result.
- **Write-then-read mode**: the rising edge of write starts the conversion, and a later read fetches the result. A read issued while the conversion is still running ends it at once.
- **Pipelined read mode**: each read pulse starts a new conversion and returns the previous result.

A busy/ready output tracks the conversion in read mode. An overflow output is always driven. A valid flag shows once enough conversions have completed for the result to be trusted.

Top module: `cnv_bus_seq`

## Requirements
- R1: After reset, `int_no` and `rdy_no` are 1, and `data_oe_o`, `ovf_o` and `valid_o` are 0.
- R2: With `mode_i`=0 and `cs_ni`=0, the clock edge that first sees `rd_ni` low starts a conversion and samples `code_i`. Exactly `CONV_CYCLES` edges later, the latch takes the sample and `int_no` goes to 0. If `rd_ni` is still low, the bus then drives the sample.
- R3: With `mode_i`=1 and `cs_ni`=0, the edge that first sees `wr_ni` high after it was low starts a conversion. `int_no` falls `CONV_CYCLES` edges later. The bus stays disabled until `rd_ni` has been seen low at an edge, and from that edge on it drives the result.
- R4: While `cs_ni` is 1, edges on `rd_ni` and `wr_ni` start nothing and enable nothing.
- R5: The edge that first sees the qualified read high again sets `int_no` to 1. If a conversion ends at the same edge, `int_no` goes to 0 instead.
- R6: In read mode, `rdy_no` goes to 0 at the edge that sees `cs_ni` fall and returns to 1 at the end of conversion. In write-then-read mode, a falling `cs_ni` leaves `rdy_no` at 1.
- R7: In write-then-read mode, if a read is seen while a conversion is running, that same edge ends the conversion. `int_no` goes to 0 and the bus drives the sampled code.
- R8: In pipelined read mode (`mode_i`=0, `pipe_i`=1), each read pulse starts a conversion. The bus is enabled from the edge after the read fall, and it drives the latch content as it stood when that pulse began.
- R9: `data_oe_o` is 0 whenever `rd_ni` or `cs_ni` is 1, and `data_o` is all zeros whenever `data_oe_o` is 0.
- R10: `ovr_i` is sampled with the code. At the end of conversion, `ovf_o` takes the sampled flag, and a result with the flag set reads as all ones. `ovf_o` does not depend on the read strobe.
- R11: Call edge 0 the edge that first sees the qualified read high again. A start request at edges 1 to `IDLE_CYCLES` is ignored and leaves the latch unchanged. A request from edge `IDLE_CYCLES`+1 onward is accepted.
- R12: `valid_o` rises at the end of the second completed conversion after reset and stays 1.
- R13: A start request while a conversion is running is ignored; the running conversion completes with its own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = read mode, 1 = write-then-read mode |
| pipe_i | input | 1 | With `mode_i`=0, selects pipelined read mode |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| code_i | input | DATA_W | Converted code, sampled at start |
| ovr_i | input | 1 | Over-range flag, sampled at start |
| data_o | output | DATA_W | Data bus value (zero while disabled) |
| data_oe_o | output | 1 | Data bus output enable |
| int_no | output | 1 | Completion interrupt, active low |
| rdy_no | output | 1 | Busy/ready in read mode, low while busy |
| ovf_o | output | 1 | Over-range of the latched result |
| valid_o | output | 1 | Two conversions have completed since reset |

## Verification
The bench builds the block with `CONV_CYCLES`=5 and `IDLE_CYCLES`=3. This makes the conversion long enough that a second write lands mid-conversion, and an early read lands well before the natural end. The three-cycle hold-off separates a rejected request at edge 3 from an accepted one at edge 4 after the read rises. Pipelined reads are spaced just past the hold-off, so each read returns the previous conversion's result.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

  typedef enum logic [1:0] {
    IF_READ       = 2'd0,
    IF_WRITE_READ = 2'd1,
    IF_PIPE       = 2'd2
  } if_mode_e;

  function automatic if_mode_e decode_mode(input logic wr_rd, input logic pipe);
    if (wr_rd)     return IF_WRITE_READ;
    else if (pipe) return IF_PIPE;
    else           return IF_READ;
  endfunction

endpackage

// File: rtl/cnv_edge.sv
module cnv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic rd_act_o,
  output logic rd_fall_o,
  output logic rd_rise_o,
  output logic rd_held_o,
  output logic wr_rise_o,
  output logic cs_fall_o
);
  logic rd_line, wr_line;
  logic rd_q, wr_q, cs_q;

  // chip select gates both strobes
  assign rd_line = rd_ni | cs_ni;
  assign wr_line = wr_ni | cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      rd_q <= rd_line;
      wr_q <= wr_line;
      cs_q <= cs_ni;
    end
  end

  assign rd_act_o  = ~rd_line;
  assign rd_fall_o = rd_q & ~rd_line;
  assign rd_rise_o = ~rd_q & rd_line;
  assign rd_held_o = ~rd_q & ~rd_line;
  assign wr_rise_o = ~wr_q & wr_line;
  assign cs_fall_o = cs_q & ~cs_ni;

endmodule

// File: rtl/cnv_timer.sv
module cnv_timer #(
  parameter int unsigned CONV_CYCLES = 4,
  parameter int unsigned IDLE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic force_i,
  input  logic rd_rise_i,
  output logic start_o,
  output logic busy_o,
  output logic eoc_o
);
  localparam int unsigned CNT_W  = $clog2(CONV_CYCLES + 1);
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 2);

  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic              busy_q;
  logic              idle_ok;

  assign idle_ok = idle_q >= IDLE_W'(IDLE_CYCLES);
  assign start_o = req_i & idle_ok & ~busy_q;
  assign eoc_o   = busy_q & ((cnt_q == '0) | force_i);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CONV_CYCLES - 1);
    end else if (eoc_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // hold-off after a read ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idle_q <= IDLE_W'(IDLE_CYCLES);
    else if (rd_rise_i) idle_q <= '0;
    else if (!idle_ok)  idle_q <= idle_q + 1'b1;
  end

  generate
    if (IDLE_CYCLES > 0) begin : g_holdoff_chk
      AST_IDLE_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_rise_i |=> !start_o); // R11
    end
  endgenerate

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !eoc_o) |=> (busy_q && !start_o)); // R13

endmodule

// File: rtl/cnv_result.sv
module cnv_result #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eoc_i,
  input  logic              snap_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] latch_o,
  output logic [DATA_W-1:0] snap_o,
  output logic              ovf_o,
  output logic              valid_o
);
  localparam int unsigned DONE_W = 2;

  logic [DATA_W-1:0] samp_q, latch_q, snap_q;
  logic              samp_ovf_q, ovf_q;
  logic [DONE_W-1:0] done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q     <= '0;
      samp_ovf_q <= 1'b0;
    end else if (start_i) begin
      samp_q     <= ovr_i ? '1 : code_i;
      samp_ovf_q <= ovr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      ovf_q   <= 1'b0;
      done_q  <= '0;
    end else if (eoc_i) begin
      latch_q <= samp_q;
      ovf_q   <= samp_ovf_q;
      if (done_q != DONE_W'(2)) done_q <= done_q + 1'b1;
    end
  end

  // pipelined read presents the latch as it stood when the pulse began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (snap_i) snap_q <= eoc_i ? samp_q : latch_q;
  end

  assign latch_o = latch_q;
  assign snap_o  = snap_q;
  assign ovf_o   = ovf_q;
  assign valid_o = done_q[1];

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R12
  AST_OVF_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (latch_q == '1)); // R10

endmodule

// File: rtl/cnv_bus_seq.sv
module cnv_bus_seq
  import cnv_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 4,
  parameter int unsigned IDLE_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              pipe_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] code_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              int_no,
  output logic              rdy_no,
  output logic              ovf_o,
  output logic              valid_o
);
  if_mode_e          mode;
  logic              rd_act, rd_fall, rd_rise, rd_held, wr_rise, cs_fall;
  logic              start_req, start, force_eoc, busy, eoc;
  logic [DATA_W-1:0] latch, snap, bus_val;
  logic              int_q, rdy_q, oe;

  assign mode = decode_mode(mode_i, pipe_i);

  cnv_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .rd_act_o  (rd_act),
    .rd_fall_o (rd_fall),
    .rd_rise_o (rd_rise),
    .rd_held_o (rd_held),
    .wr_rise_o (wr_rise),
    .cs_fall_o (cs_fall)
  );

  assign start_req = (mode == IF_WRITE_READ) ? wr_rise : rd_fall;
  // early read in write-then-read mode cuts the conversion short
  assign force_eoc = (mode == IF_WRITE_READ) & busy & rd_act;

  cnv_timer #(
    .CONV_CYCLES (CONV_CYCLES),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (start_req),
    .force_i   (force_eoc),
    .rd_rise_i (rd_rise),
    .start_o   (start),
    .busy_o    (busy),
    .eoc_o     (eoc)
  );

  cnv_result #(
    .DATA_W (DATA_W)
  ) u_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .eoc_i   (eoc),
    .snap_i  (rd_fall),
    .code_i  (code_i),
    .ovr_i   (ovr_i),
    .latch_o (latch),
    .snap_o  (snap),
    .ovf_o   (ovf_o),
    .valid_o (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      int_q <= 1'b1;
    else if (eoc)     int_q <= 1'b0;
    else if (rd_rise) int_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rdy_q <= 1'b1;
    else if (eoc)                               rdy_q <= 1'b1;
    else if (cs_fall && mode != IF_WRITE_READ)  rdy_q <= 1'b0;
    else if (cs_ni && !busy)                    rdy_q <= 1'b1;
  end

  assign oe        = rd_held & ((mode == IF_PIPE) | ~busy);
  assign bus_val   = (mode == IF_PIPE) ? snap : latch;
  assign data_o    = oe ? bus_val : '0;
  assign data_oe_o = oe;
  assign int_no    = int_q;
  assign rdy_no    = rdy_q;

  AST_INT_ON_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc |=> !int_no); // R2
  AST_EARLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && busy && rd_act) |=> (!int_no && !busy)); // R7
  AST_CS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!start && !data_oe_o)); // R4
  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> (!data_oe_o && data_o == '0)); // R9

endmodule

// File: tb/cnv_bus_seq_tb_top.sv
module cnv_bus_seq_tb_top;
  localparam int C = 5;
  localparam int I = 3;

  typedef struct packed {
    logic [7:0] code;
    logic       ovf;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0, pipe_i = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] code_i = '0;
  logic       ovr_i = 1'b0;
  logic [7:0] data_o;
  logic       data_oe_o, int_no, rdy_no, ovf_o, valid_o;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  logic int_prev = 1'b1;

  always #5 clk_i = ~clk_i;

  cnv_bus_seq #(.DATA_W(8), .CONV_CYCLES(C), .IDLE_CYCLES(I)) dut_i (
    .clk_i, .rst_ni, .mode_i, .pipe_i, .cs_ni, .rd_ni, .wr_ni,
    .code_i, .ovr_i, .data_o, .data_oe_o, .int_no, .rdy_no, .ovf_o, .valid_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic push(input logic [7:0] c, input logic o);
    exp_t e;
    e.code = c;
    e.ovf  = o;
    exp_q.push_back(e);
  endtask

  // monitor: each completion pops one expected item
  always @(negedge clk_i) begin
    int_prev <= int_no;
    if (rst_ni && int_prev && !int_no) begin
      if (exp_q.size() == 0) chk("R2 unexpected completion", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R10 ovf at completion", ovf_o, e.ovf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 int", int_no, 1);
    chk("R1 rdy", rdy_no, 1);
    chk("R1 oe", data_oe_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 valid", valid_o, 0);

    // read mode
    cs_ni = 0; code_i = 8'h5A; push(8'h5A, 0);
    cyc(1);
    chk("R6 rdy low after cs fall", rdy_no, 0);
    rd_ni = 0;
    #1 chk("R9 oe off at fall", data_oe_o, 0);
    cyc(1);
    code_i = 8'hFF;
    cyc(C - 1);
    chk("R2 int before end", int_no, 1);
    chk("R2 oe before end", data_oe_o, 0);
    cyc(1);
    chk("R2 int at end", int_no, 0);
    chk("R2 data", data_o, 8'h5A);
    chk("R6 rdy high at end", rdy_no, 1);
    chk("R12 valid after first", valid_o, 0);
    rd_ni = 1;
    #1 chk("R9 oe off", data_oe_o, 0);
    chk("R9 data zero", data_o, 0);
    cyc(1);
    chk("R5 int cleared", int_no, 1);
    cs_ni = 1;
    cyc(5);

    // hold-off
    cs_ni = 0; rd_ni = 0; code_i = 8'h11; push(8'h11, 0);
    cyc(1 + C);
    chk("R2 second result", data_o, 8'h11);
    chk("R12 valid after second", valid_o, 1);
    rd_ni = 1;
    cyc(1);
    cyc(2);
    rd_ni = 0; code_i = 8'h22;
    cyc(1 + C + 1);
    chk("R11 early start ignored", int_no, 1);
    chk("R11 latch kept", data_o, 8'h11);
    rd_ni = 1;
    cyc(1);
    cyc(3);
    rd_ni = 0; code_i = 8'h33; push(8'h33, 0);
    cyc(1 + C);
    chk("R11 late start taken", int_no, 0);
    chk("R11 late data", data_o, 8'h33);
    rd_ni = 1; cs_ni = 1;
    cyc(5);

    // chip select high
    rd_ni = 0;
    cyc(C + 2);
    chk("R4 rd without cs", int_no, 1);
    chk("R4 oe without cs", data_oe_o, 0);
    rd_ni = 1; mode_i = 1;
    wr_ni = 0; cyc(1); wr_ni = 1;
    cyc(C + 2);
    chk("R4 wr without cs", int_no, 1);

    // write-then-read
    cs_ni = 0; code_i = 8'h44; wr_ni = 0;
    cyc(1);
    wr_ni = 1; push(8'h44, 0);
    cyc(1);
    cyc(C);
    chk("R3 int", int_no, 0);
    chk("R3 oe before read", data_oe_o, 0);
    chk("R6 rdy in write mode", rdy_no, 1);
    rd_ni = 0;
    cyc(1);
    chk("R3 oe on read", data_oe_o, 1);
    chk("R3 data", data_o, 8'h44);
    rd_ni = 1;
    cyc(1);
    chk("R5 int cleared wr mode", int_no, 1);
    cyc(4);

    // early read
    code_i = 8'h77; wr_ni = 0;
    cyc(1);
    wr_ni = 1; push(8'h77, 0);
    cyc(1);
    chk("R7 busy before read", int_no, 1);
    rd_ni = 0;
    cyc(1);
    chk("R7 int forced", int_no, 0);
    chk("R7 data forced", data_o, 8'h77);
    rd_ni = 1;
    cyc(1);
    cyc(4);

    // overflow
    code_i = 8'h12; ovr_i = 1; wr_ni = 0; push(8'hFF, 1);
    cyc(1);
    wr_ni = 1;
    cyc(1);
    ovr_i = 0;
    cyc(C - 1);
    chk("R10 ovf before end", ovf_o, 0);
    cyc(1);
    chk("R10 ovf at end", ovf_o, 1);
    rd_ni = 0;
    cyc(1);
    chk("R10 data all ones", data_o, 8'hFF);
    rd_ni = 1;
    cyc(1);
    chk("R10 ovf with rd high", ovf_o, 1);
    cyc(4);
    code_i = 8'h05; wr_ni = 0; push(8'h05, 0);
    cyc(1);
    wr_ni = 1;
    cyc(1);
    cyc(C);
    chk("R10 ovf cleared", ovf_o, 0);
    rd_ni = 0; cyc(1);
    chk("R10 data normal", data_o, 8'h05);
    rd_ni = 1; cyc(1);
    cyc(4);

    // start while busy
    code_i = 8'h66; wr_ni = 0; push(8'h66, 0);
    cyc(1);
    wr_ni = 1;
    cyc(1);
    code_i = 8'h99; wr_ni = 0;
    cyc(1);
    wr_ni = 1;
    cyc(1);
    cyc(C - 2);
    chk("R13 first completes", int_no, 0);
    rd_ni = 0; cyc(1);
    chk("R13 own sample", data_o, 8'h66);
    rd_ni = 1; cyc(1);
    cyc(C + 2);
    chk("R13 no second", int_no, 1);

    // pipelined read
    mode_i = 0; pipe_i = 1;
    cyc(4);
    code_i = 8'hA1; rd_ni = 0; push(8'hA1, 0);
    cyc(1);
    cyc(1);
    chk("R8 previous result", data_o, 8'h66);
    chk("R8 oe while busy", data_oe_o, 1);
    rd_ni = 1;
    cyc(1);
    cyc(3);
    chk("R8 first pipe done", int_no, 0);
    cyc(1);
    code_i = 8'hB2; rd_ni = 0; push(8'hB2, 0);
    cyc(1);
    cyc(1);
    chk("R8 second read", data_o, 8'hA1);
    rd_ni = 1;
    cyc(1);
    cyc(C + 4);
    rd_ni = 0; code_i = 8'hC3; push(8'hC3, 0);
    cyc(2);
    chk("R8 third read", data_o, 8'hB2);
    rd_ni = 1;
    cyc(C + 2);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule